// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single burst request into the run of column addresses that a DRAM-style read or write burst visits. A request carries a starting column, a burst-length code and an ordering choice. The block then emits one column address per beat, together with a valid strobe and a flag on the final beat. It runs in a beat-rate clock domain, so each clock cycle of this block is one data beat.

The burst is confined to a block of columns aligned to the burst length. Only the low column bits inside that block change. They wrap at the block edge, and the column bits above the burst field stay as they were at the start. Two orderings are available:

- **Linear:** the low field counts up from its start value, modulo the burst length.
- **Interleaved:** the low field is the start value XORed with the beat index.

A new request arriving while a burst is still running abandons the old burst and starts the new one.

Top module: `burst_col_seq`

## Requirements
- R1: Out of reset, and while reset is held, `beat_valid_o` and `beat_last_o` are low.
- R2: In the cycle after a clock edge that samples `req_i` high, `beat_valid_o` is high and `beat_col_o` equals the `req_col_i` value captured at that edge.
- R3: `len_code_i` selects the burst length: 0 gives 2 beats, 1 gives 4 beats, 2 gives 8 beats. `beat_valid_o` stays high for exactly that many consecutive cycles when no new request intervenes.
- R4: With `order_i` = 0 (linear), the low log2(BL) bits of beat i are (start + i) mod BL. For example, BL 4 from 1 gives 1,2,3,0, and BL 8 from 6 gives 6,7,0,1,2,3,4,5.
- R5: With `order_i` = 1 (interleaved), the low log2(BL) bits of beat i are start XOR i. For example, BL 4 from 1 gives 1,0,3,2; BL 4 from 3 gives 3,2,1,0; BL 8 from 5 gives 5,4,7,6,1,0,3,2.
- R6: Column bits at and above bit log2(BL) of `beat_col_o` equal those of the start column on every beat of the burst.
- R7: `beat_last_o` is high only on beat BL-1 of a burst, and never while `beat_valid_o` is low.
- R8: A request sampled while a burst is running, including on its last beat, abandons that burst. The next cycle shows beat 0 of the new burst.
- R9: `len_code_i` = 3 is treated as a burst length of 8.
- R10: After the last beat, if no request is sampled on that edge, `beat_valid_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start strobe for a new burst |
| req_col_i | input | 9 | Starting column of the burst |
| len_code_i | input | 2 | Burst length code (0:2, 1:4, 2:8, 3:8) |
| order_i | input | 1 | 0 linear, 1 interleaved |
| beat_col_o | output | 9 | Column address of the current beat |
| beat_valid_o | output | 1 | A burst beat is presented this cycle |
| beat_last_o | output | 1 | Current beat is the final one of the burst |

## Verification
The bench targets start columns whose low field is non-zero and whose upper bits are set.

- **Wrap and carry:** a design that let the carry escape the burst field would change the upper column bits when the field wraps. A design that wrapped at the wrong width would visit columns outside the aligned block.
- **Ordering:** interleaved bursts from odd starts are checked beat by beat. An adder used in place of the XOR produces 1,2,3,0 where 1,0,3,2 is expected.
- **Restarts:** requests are issued mid-burst and on the last beat. A design that ignored them would keep counting the old sequence, and one that dropped them on the final beat would show a gap in `beat_valid_o`.
- **Length codes:** the reserved length code is exercised. A design that mapped it to a shorter length would end the burst early and raise `beat_last_o` on the wrong beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Ordering of the low column field across a burst
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Burst-length code width at the block edge
  localparam int LEN_CODE_W = 2;

endpackage

// File: rtl/bcs_cfg_reg.sv
// Holds the parameters of the burst in flight: base column, field mask, order.
module bcs_cfg_reg
  import burst_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LOG_MAX = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  order_i,
  output logic [COL_W-1:0]      base_o,
  output logic [LOG_MAX-1:0]    mask_o,
  output order_e                order_o
);

  logic [COL_W-1:0]   base_q, base_d;
  logic [LOG_MAX-1:0] mask_q, mask_d;
  order_e             ord_q, ord_d;
  logic [LOG_MAX-1:0] mask_new;

  // Field mask: bit b is part of the burst field when b <= code.
  // Codes beyond the widest field saturate at LOG_MAX bits.
  always_comb begin
    for (int b = 0; b < LOG_MAX; b++) begin
      mask_new[b] = (int'(code_i) >= b);
    end
  end

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    ord_d  = ord_q;
    if (load_i) begin
      base_d = col_i;
      mask_d = mask_new;
      ord_d  = order_e'(order_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ord_q  <= ORD_LINEAR;
    end else if (load_i) begin
      base_q <= base_d;
      mask_q <= mask_d;
      ord_q  <= ord_d;
    end
  end

  assign base_o  = base_q;
  assign mask_o  = mask_q;
  assign order_o = ord_q;

endmodule

// File: rtl/bcs_beat_ctr.sv
// Beat counter: tracks the beat index and whether a burst is running.
module bcs_beat_ctr #(
  parameter int LOG_MAX = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [LOG_MAX-1:0] mask_i,
  output logic [LOG_MAX-1:0] cnt_o,
  output logic               busy_o,
  output logic               last_o
);

  logic [LOG_MAX-1:0] cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic               is_last;
  logic               cnt_en;

  assign is_last = busy_q && (cnt_q == mask_i);
  assign cnt_en  = start_i || busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start_i) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (is_last) begin
        cnt_d  = '0;
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
  assign last_o = is_last;

endmodule

// File: rtl/bcs_col_mix.sv
// Forms the beat column: burst field from the order rule, upper bits from base.
module bcs_col_mix
  import burst_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LOG_MAX = 3
) (
  input  logic [COL_W-1:0]   base_i,
  input  logic [LOG_MAX-1:0] mask_i,
  input  order_e             order_i,
  input  logic [LOG_MAX-1:0] cnt_i,
  output logic [COL_W-1:0]   col_o
);

  logic [LOG_MAX-1:0] low_sum;
  logic [LOG_MAX-1:0] low_xor;
  logic [LOG_MAX-1:0] low_sel;

  // The sum wraps modulo 2^LOG_MAX. Masking it per bit below gives modulo BL,
  // because a carry only moves toward higher bits.
  assign low_sum = base_i[LOG_MAX-1:0] + cnt_i;
  assign low_xor = base_i[LOG_MAX-1:0] ^ cnt_i;
  assign low_sel = (order_i == ORD_XOR) ? low_xor : low_sum;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < LOG_MAX) begin : g_field
      assign col_o[b] = mask_i[b] ? low_sel[b] : base_i[b];
    end else begin : g_upper
      assign col_o[b] = base_i[b];
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LOG_MAX = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [COL_W-1:0]      req_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  output logic [COL_W-1:0]      beat_col_o,
  output logic                  beat_valid_o,
  output logic                  beat_last_o
);

  logic [COL_W-1:0]   base;
  logic [LOG_MAX-1:0] mask;
  order_e             ord;
  logic [LOG_MAX-1:0] cnt;

  bcs_cfg_reg #(.COL_W(COL_W), .LOG_MAX(LOG_MAX)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (req_i),
    .col_i   (req_col_i),
    .code_i  (len_code_i),
    .order_i (order_i),
    .base_o  (base),
    .mask_o  (mask),
    .order_o (ord)
  );

  bcs_beat_ctr #(.LOG_MAX(LOG_MAX)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (req_i),
    .mask_i  (mask),
    .cnt_o   (cnt),
    .busy_o  (beat_valid_o),
    .last_o  (beat_last_o)
  );

  bcs_col_mix #(.COL_W(COL_W), .LOG_MAX(LOG_MAX)) u_mix (
    .base_i  (base),
    .mask_i  (mask),
    .order_i (ord),
    .cnt_i   (cnt),
    .col_o   (beat_col_o)
  );

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W   = 9,
  parameter int LOG_MAX = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic [COL_W-1:0] req_col_i,
  input logic [COL_W-1:0] beat_col_o,
  input logic             beat_valid_o,
  input logic             beat_last_o
);

  // R2
  req_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (beat_valid_o && beat_col_o == $past(req_col_i)));

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid_o) |-> $past(req_i));

  // R7
  last_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_valid_o);

  // R10
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last_o && !req_i) |=> !beat_valid_o);

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !req_i) |=>
      (!beat_valid_o || beat_col_o[COL_W-1:LOG_MAX] == $past(beat_col_o[COL_W-1:LOG_MAX])));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .LOG_MAX(LOG_MAX)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .req_col_i    (req_col_i),
  .beat_col_o   (beat_col_o),
  .beat_valid_o (beat_valid_o),
  .beat_last_o  (beat_last_o)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

  logic       clk;
  logic       rst_n;
  logic       req_i;
  logic [8:0] req_col_i;
  logic [1:0] len_code_i;
  logic       order_i;
  logic [8:0] beat_col_o;
  logic       beat_valid_o;
  logic       beat_last_o;

  int checks;
  int fails;
  bit done;

  burst_col_seq i_burst_col_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .req_col_i    (req_col_i),
    .len_code_i   (len_code_i),
    .order_i      (order_i),
    .beat_col_o   (beat_col_o),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // R3, R9: burst length from the code
  function automatic int blen(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 4;
      default: return 8;
    endcase
  endfunction

  // R4, R5, R6: expected column of beat i
  function automatic logic [8:0] exp_col(input logic [8:0] s, input logic [1:0] code,
                                         input bit il, input int i);
    int bl = blen(code);
    int lo = int'(s) % bl;
    int n  = il ? (lo ^ i) : ((lo + i) % bl);
    return 9'(int'(s) - lo + n);
  endfunction

  // Drive a request at the current negedge; returns at the next negedge.
  task automatic launch(input logic [8:0] s, input logic [1:0] code, input bit il);
    req_i      = 1'b1;
    req_col_i  = s;
    len_code_i = code;
    order_i    = il;
    @(negedge clk);
    req_i      = 1'b0;
    req_col_i  = $urandom;
    len_code_i = 2'($urandom);
    order_i    = 1'($urandom);
  endtask

  // Check beats 0..n-1; returns at the negedge after the last one checked.
  task automatic check_beats(input logic [8:0] s, input logic [1:0] code, input bit il,
                             input int n, input string tag);
    int bl = blen(code);
    for (int i = 0; i < n; i++) begin
      logic [8:0] ec = exp_col(s, code, il, i);
      bit el = (i == bl - 1);
      checks++;
      if (beat_col_o !== ec || beat_valid_o !== 1'b1 || beat_last_o !== el) begin
        fails++;
        $display("FAIL %s beat %0d: col=%0d valid=%b last=%b expected col=%0d valid=1 last=%b",
                 tag, i, beat_col_o, beat_valid_o, beat_last_o, ec, el);
      end
      @(negedge clk);
    end
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (beat_valid_o !== 1'b0 || beat_last_o !== 1'b0) begin
      fails++;
      $display("FAIL %s idle: valid=%b last=%b expected valid=0 last=0",
               tag, beat_valid_o, beat_last_o);
    end
  endtask

  task automatic full_burst(input logic [8:0] s, input logic [1:0] code, input bit il,
                            input string tag);
    launch(s, code, il);
    check_beats(s, code, il, blen(code), tag);
    check_idle({tag, " R10"});
  endtask

  initial begin
    int unused_seed;
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    unused_seed = $urandom(32'h1d5a);
    rst_n      = 1'b0;
    req_i      = 1'b0;
    req_col_i  = '0;
    len_code_i = '0;
    order_i    = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    // Directed orders: R4 linear, R5 interleaved, R6 upper bits kept
    full_burst(9'h1F1, 2'd1, 1'b0, "R4 BL4 lin from 1");
    full_burst(9'h0A1, 2'd1, 1'b1, "R5 BL4 xor from 1");
    full_burst(9'h153, 2'd1, 1'b1, "R5 BL4 xor from 3");
    full_burst(9'h1FD, 2'd2, 1'b1, "R5 BL8 xor from 5");
    full_burst(9'h0EE, 2'd2, 1'b0, "R4 BL8 lin from 6");
    full_burst(9'h1FF, 2'd0, 1'b0, "R3 BL2 lin from 1");
    full_burst(9'h0F7, 2'd3, 1'b0, "R9 code3 lin from 7");
    full_burst(9'h1FF, 2'd2, 1'b0, "R6 BL8 top wrap");

    // R8: restart mid-burst
    launch(9'h1F5, 2'd2, 1'b0);
    check_beats(9'h1F5, 2'd2, 1'b0, 3, "R8 first");
    launch(9'h02A, 2'd1, 1'b1);
    check_beats(9'h02A, 2'd1, 1'b1, 4, "R8 second");
    check_idle("R8 R10 after second");

    // R8: restart on the last beat, no gap
    launch(9'h113, 2'd1, 1'b0);
    check_beats(9'h113, 2'd1, 1'b0, 3, "R8 lastbeat A");
    launch(9'h066, 2'd2, 1'b1);
    check_beats(9'h066, 2'd2, 1'b1, 8, "R8 lastbeat B");
    check_idle("R8 R10 lastbeat end");

    // Random bursts, some restarted early (R3 R4 R5 R6 R7 R8)
    for (int k = 0; k < 300; k++) begin
      logic [8:0] s    = 9'($urandom);
      logic [1:0] code = 2'($urandom);
      bit         il   = 1'($urandom);
      int         cut  = $urandom_range(0, 3);
      launch(s, code, il);
      if (cut == 0 && blen(code) > 1) begin
        check_beats(s, code, il, $urandom_range(1, blen(code) - 1), "R8 rand cut");
      end else begin
        check_beats(s, code, il, blen(code), "R7 rand");
        check_idle("R10 rand");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: expected test completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule